// File: doc/BRIEF.md
# Ordered Dithering Threshold Unit

This block turns a stream of 8-bit grayscale pixels into a two-level halftone. Each pixel is compared with a threshold taken from a small tile of fixed levels that repeats across the image. The column within the tile advances with every pixel and wraps at the tile width. The tile row is selected by the line count and wraps at the tile height. A pixel brighter than its threshold leaves as full white, and any other pixel leaves as full black.

Pixels enter on a valid/ready stream. A start-of-line flag travels with the first pixel of each line. Results leave on a second valid/ready stream in the order the pixels came in. The pipeline has two register stages and can take one pixel per cycle. Downstream backpressure is passed back to the input only when both stages are full.

Top module: `ordered_dither`

## Requirements
- R1: While reset is asserted and right after it, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: On tile row 0 the thresholds for columns 0, 1, 2, 3 are 32, 160, 224, 96.
- R3: On tile row 1 the thresholds for columns 0, 1, 2, 3 are 224, 96, 32, 160.
- R4: The compare is an unsigned strict greater-than. A pixel above its threshold gives 255. A pixel equal to or below it gives 0.
- R5: Within a line the column index goes up by one for each accepted pixel and wraps from 3 to 0.
- R6: A pixel accepted with `in_sol_i` = 1 uses column 0. The first such pixel after reset uses row 0. Each later one uses the other row from the line before it.
- R7: Pixels accepted after reset and before any start-of-line use row 0, with columns counting from 0.
- R8: With `out_ready_i` held at 1, a pixel accepted in cycle n shows its result with `out_valid_o` = 1 in cycle n+2, and one pixel per cycle is sustained.
- R9: While `out_valid_o` = 1 and `out_ready_i` = 0, `out_valid_o` stays 1 and `out_pix_o` stays unchanged. No result is lost, duplicated or reordered.
- R10: Whenever `out_valid_o` = 1, `out_pix_o` is 0 or 255.
- R11: `in_ready_o` is 0 only while a result is waiting and `out_ready_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Unit can accept a pixel |
| in_sol_i | input | 1 | Pixel is the first of a line |
| in_pix_i | input | 8 | Grayscale pixel, unsigned |
| out_valid_o | output | 1 | Halftone result valid |
| out_ready_i | input | 1 | Downstream can take the result |
| out_pix_o | output | 8 | Result, 0 or 255 |

## Verification
Every result is due exactly two cycles after its pixel is accepted when downstream is ready. The bench notes the falling-edge cycle in which each handshake is set up. It then checks both the value and that two-cycle gap when the result is taken. Under backpressure the gap is no longer fixed. The bench then checks that the waiting result stays unchanged, that the input refuses new pixels, and that the held pixels drain in order once ready returns.

// File: rtl/od_pkg.sv
package od_pkg;
  localparam int unsigned LEVEL_W = 3;

  // eighth-scale level; each tile row is the base row rotated by two columns
  function automatic int unsigned tile_level(int unsigned row, int unsigned col);
    int unsigned k;
    k = (col + 2 * row) % 4;
    case (k)
      0:       return 1;
      1:       return 5;
      2:       return 7;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/od_pos_tracker.sv
module od_pos_tracker #(
  parameter int unsigned TILE_W = 4,
  parameter int unsigned TILE_H = 2,
  localparam int unsigned COL_W = (TILE_W > 1) ? $clog2(TILE_W) : 1,
  localparam int unsigned ROW_W = (TILE_H > 1) ? $clog2(TILE_H) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             sol_i,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  logic [COL_W-1:0] col_q, col_nxt;
  logic [ROW_W-1:0] row_q, row_adv;
  logic             started_q;

  always_comb begin
    row_adv = (row_q == ROW_W'(TILE_H - 1)) ? '0 : row_q + 1'b1;
    col_o   = sol_i ? '0 : col_q;
    row_o   = sol_i ? (started_q ? row_adv : '0) : row_q;
    col_nxt = (col_o == COL_W'(TILE_W - 1)) ? '0 : col_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q     <= '0;
      row_q     <= '0;
      started_q <= 1'b0;
    end else if (step_i) begin
      col_q <= col_nxt;
      row_q <= row_o;
      if (sol_i) started_q <= 1'b1;
    end
  end

  a_r6_col_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && sol_i |=> col_q == COL_W'((TILE_W > 1) ? 1 : 0));

  a_r6_first_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && sol_i && !started_q |=> row_q == '0);

  a_r5_col_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !sol_i && col_q == COL_W'(TILE_W - 1) |=> col_q == '0);

  generate
    if (TILE_H > 1) begin : g_row_chk
      a_r6_row_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && sol_i && started_q |=> row_q != $past(row_q));
    end
  endgenerate
endmodule

// File: rtl/od_threshold_lut.sv
module od_threshold_lut #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned TILE_W = 4,
  parameter int unsigned TILE_H = 2,
  localparam int unsigned COL_W = (TILE_W > 1) ? $clog2(TILE_W) : 1,
  localparam int unsigned ROW_W = (TILE_H > 1) ? $clog2(TILE_H) : 1
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [PIX_W-1:0] thr_o
);
  localparam int unsigned SHIFT = PIX_W - od_pkg::LEVEL_W;

  logic [PIX_W-1:0] tab [TILE_H][TILE_W];

  for (genvar r = 0; r < TILE_H; r++) begin : g_row
    for (genvar c = 0; c < TILE_W; c++) begin : g_col
      assign tab[r][c] = PIX_W'(od_pkg::tile_level(r, c)) << SHIFT;
    end
  end

  assign thr_o = tab[row_i][col_i];
endmodule

// File: rtl/od_pipe_stage.sv
module od_pipe_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [WIDTH-1:0] data_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [WIDTH-1:0] data_o
);
  logic             valid_q;
  logic [WIDTH-1:0] data_q;

  assign ready_o = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (ready_o) begin
      valid_q <= valid_i;
      if (valid_i) data_q <= data_i;
    end
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
endmodule

// File: rtl/ordered_dither.sv
module ordered_dither #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned TILE_W = 4,
  parameter int unsigned TILE_H = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             in_sol_i,
  input  logic [PIX_W-1:0] in_pix_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PIX_W-1:0] out_pix_o
);
  localparam int unsigned COL_W = (TILE_W > 1) ? $clog2(TILE_W) : 1;
  localparam int unsigned ROW_W = (TILE_H > 1) ? $clog2(TILE_H) : 1;

  logic             accept;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [PIX_W-1:0] thr;
  logic             s1_valid, s2_ready;
  logic [2*PIX_W-1:0] s1_data;
  logic [PIX_W-1:0] s1_pix, s1_thr, decided;

  assign accept = in_valid_i && in_ready_o;

  od_pos_tracker #(.TILE_W(TILE_W), .TILE_H(TILE_H)) u_pos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(accept),
    .sol_i (in_sol_i),
    .col_o (col),
    .row_o (row)
  );

  od_threshold_lut #(.PIX_W(PIX_W), .TILE_W(TILE_W), .TILE_H(TILE_H)) u_lut (
    .col_i(col),
    .row_i(row),
    .thr_o(thr)
  );

  od_pipe_stage #(.WIDTH(2 * PIX_W)) u_s1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .ready_o(in_ready_o),
    .data_i ({in_pix_i, thr}),
    .valid_o(s1_valid),
    .ready_i(s2_ready),
    .data_o (s1_data)
  );

  assign s1_pix  = s1_data[2*PIX_W-1:PIX_W];
  assign s1_thr  = s1_data[PIX_W-1:0];
  assign decided = (s1_pix > s1_thr) ? '1 : '0;

  od_pipe_stage #(.WIDTH(PIX_W)) u_s2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s1_valid),
    .ready_o(s2_ready),
    .data_i (decided),
    .valid_o(out_valid_o),
    .ready_i(out_ready_i),
    .data_o (out_pix_o)
  );

  a_r10_binary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_pix_o == '0 || out_pix_o == '1));

  a_r11_stall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> out_valid_o && !out_ready_i);

  a_r8_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid && s2_ready |=> out_valid_o);

  a_r4_equal_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid && s2_ready && s1_pix == s1_thr |=> out_pix_o == '0);
endmodule

// File: tb/ordered_dither_tb.sv
`timescale 1ns/1ps
module ordered_dither_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic       in_sol_i = 1'b0;
  logic [7:0] in_pix_i = '0;
  logic       out_valid_o;
  logic       out_ready_i = 1'b1;
  logic [7:0] out_pix_o;

  always #2 clk = ~clk;

  ordered_dither u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_sol_i   (in_sol_i),
    .in_pix_i   (in_pix_i),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_pix_o  (out_pix_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // {sol, pixel, expected}
  localparam int NV = 20;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {1'b0, 8'd33,  8'd255},  // R7 row0 c0 t32
    {1'b0, 8'd160, 8'd0},    // R7 R4 c1 t160 equal
    {1'b1, 8'd100, 8'd255},  // R6 first line row0 c0
    {1'b0, 8'd161, 8'd255},  // R2 c1 t160
    {1'b0, 8'd224, 8'd0},    // R2 R4 c2 t224 equal
    {1'b0, 8'd97,  8'd255},  // R2 c3 t96
    {1'b0, 8'd31,  8'd0},    // R5 wrap c0 t32
    {1'b0, 8'd159, 8'd0},    // R5 c1 t160
    {1'b1, 8'd225, 8'd255},  // R3 R6 row1 c0 t224
    {1'b0, 8'd96,  8'd0},    // R3 c1 t96
    {1'b0, 8'd33,  8'd255},  // R3 c2 t32
    {1'b0, 8'd160, 8'd0},    // R3 c3 t160
    {1'b0, 8'd200, 8'd0},    // R5 R4 wrap c0 t224, unsigned
    {1'b0, 8'd97,  8'd255},  // R3 c1 t96
    {1'b1, 8'd33,  8'd255},  // R6 back to row0 c0
    {1'b0, 8'd255, 8'd255},  // R2 c1
    {1'b0, 8'd0,   8'd0},    // R2 c2
    {1'b1, 8'd250, 8'd255},  // R6 row1 short line
    {1'b1, 8'd100, 8'd255},  // R6 row0
    {1'b1, 8'd100, 8'd0}     // R6 row1 c0 t224
  };
  localparam int TAG [0:NV-1] = '{7,7,6,2,4,2,5,5,3,3,3,3,5,3,6,2,2,6,6,6};

  int         ncyc = 0;
  int         wr_idx = 0;
  int         rd_idx = 0;
  logic [7:0] exp_next = '0;
  int         tag_next = 0;
  logic       lat_chk = 1'b0;
  logic [7:0] exp_mem [0:63];
  int         acc_cyc [0:63];
  int         tag_mem [0:63];

  // monitor: R8 latency, R9 order, R10 values
  always @(negedge clk) begin
    if (rst_ni) begin
      if (out_valid_o && out_ready_i) begin
        chk($sformatf("R%0d value item %0d", tag_mem[rd_idx], rd_idx), out_pix_o, exp_mem[rd_idx]);
        chk("R10 output binary", int'(out_pix_o == 8'd0 || out_pix_o == 8'd255), 1);
        if (lat_chk) chk("R8 latency", ncyc - acc_cyc[rd_idx], 2);
        rd_idx++;
      end
      if (in_valid_i && in_ready_o) begin
        exp_mem[wr_idx] = exp_next;
        tag_mem[wr_idx] = tag_next;
        acc_cyc[wr_idx] = ncyc;
        wr_idx++;
      end
    end
    ncyc++;
  end

  task automatic push(input logic sol, input logic [7:0] pix, input logic [7:0] exp, input int tag);
    in_valid_i = 1'b1;
    in_sol_i   = sol;
    in_pix_i   = pix;
    exp_next   = exp;
    tag_next   = tag;
    do @(negedge clk); while (!in_ready_o);
    @(posedge clk);
    #1 in_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid_o), 0);
    chk("R1 in_ready in reset", int'(in_ready_o), 1);
    @(posedge clk); #1 rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid_o), 0);
    chk("R1 in_ready after reset", int'(in_ready_o), 1);

    // table walk, streamed one per cycle (R8)
    @(posedge clk); #1 lat_chk = 1'b1;
    for (int i = 0; i < NV; i++)
      push(VEC[i][16], VEC[i][15:8], VEC[i][7:0], TAG[i]);
    repeat (5) @(negedge clk);
    chk("R8 all table results delivered", rd_idx, NV);
    lat_chk = 1'b0;

    // backpressure: R9, R11
    @(posedge clk); #1 out_ready_i = 1'b0;
    push(1'b1, 8'd100, 8'd255, 9);  // row0 c0 t32
    push(1'b0, 8'd150, 8'd0, 9);    // c1 t160
    in_valid_i = 1'b1; in_sol_i = 1'b0; in_pix_i = 8'd230; exp_next = 8'd255; tag_next = 9; // c2 t224
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 in_ready low when full", int'(in_ready_o), 0);
      chk("R9 out_valid held", int'(out_valid_o), 1);
      chk("R9 out_pix held", out_pix_o, 255);
    end
    @(posedge clk); #1 out_ready_i = 1'b1;
    do @(negedge clk); while (!in_ready_o);
    @(posedge clk); #1 in_valid_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 no loss or duplicate", rd_idx, wr_idx);
    chk("R9 count", rd_idx, NV + 3);
    chk("R1 idle after drain", int'(out_valid_o), 0);

    summary();
    $finish;
  end
endmodule